// File: doc/BRIEF.md
# Switch Port Bring-Up Sequencer

This block is a master-side controller that prepares an attached Ethernet switch for traffic once its own reset is released. It has no software interface. It issues a fixed series of 32-bit register reads and writes through a generic request port. Each request carries a block number, a subblock number, a register address and write data. A transport agent returns `done_i` with read data and a transport-error flag.

The sequence has four phases. It first probes a mailbox register, and if that read returns all ones it pulses the switch reset pin and then waits. It then reads the chip identity and checks it. Next it programs two registers with write-then-verify steps, where the readback is compared under a mask. Finally it writes the port MAC configuration twice: the first write holds the port in reset and the second sets the run value. The block ends in a sticky success state or in a sticky error state that carries a code. The identity and revision fields read from the switch are kept on outputs.

Top module: `sw_bringup_seq`

## Requirements
- R1: While `rst_ni` is low, `req_o`, `switch_reset_o`, `done_o` and `err_o` are 0 and `err_code_o` is 0. After release, the first request is a read (`req_write_o`=0) of block 7, subblock 0, register 0x15.
- R2: If that read returns 0xFFFFFFFF, `switch_reset_o` is high for exactly RST_PULSE_CYCLES cycles. No request is raised while it is high, nor for RST_WAIT_CYCLES cycles after it falls. For any other value no pulse occurs.
- R3: The next request reads block 7, subblock 0, register 0x18. Bits 27:12 of the result appear on `chip_id_o` and bits 31:28 on `chip_rev_o`. If the ID is neither 0x7385 nor 0x7395, the run ends with `err_o`=1 and `err_code_o`=1.
- R4: The block writes 0x33 to block 7, subblock 0, register 0x05 and then reads that register back. If (readback AND 0x33) is not 0x33, the run ends with `err_code_o`=2.
- R5: The block writes 0x2C (bits 5, 3 and 2 set) to block 1, subblock 6, register 0x19 and then reads it back. If (readback AND 0xFF) is not 0x2C, the run ends with `err_code_o`=2. Readback bits outside the mask have no effect.
- R6: The block writes 0x20000030 to block 1, subblock 6, register 0x00, then writes 0x10070184 to the same register. These are the last two requests. `done_o` then goes to 1 with `err_code_o`=0.
- R7: If `xfer_err_i` is high with `done_i` on any transfer, the run ends at once with `err_code_o`=3 and no further request.
- R8: `req_write_o`, `req_block_o`, `req_subblock_o`, `req_reg_o` and `req_wdata_o` stay stable while `req_o` is high. `req_o` falls in the cycle after `done_i`. `done_i` (and `xfer_err_i`) while `req_o` is low has no effect.
- R9: After `done_o` or `err_o` goes high, it stays high with an unchanged code, and no request is issued until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_o | output | 1 | Transfer request, held until `done_i` |
| req_write_o | output | 1 | 1 = write, 0 = read |
| req_block_o | output | 3 | Target block |
| req_subblock_o | output | 4 | Target subblock |
| req_reg_o | output | 8 | Register address |
| req_wdata_o | output | 32 | Write data (0 on reads) |
| done_i | input | 1 | Transfer completion strobe |
| rdata_i | input | 32 | Read data, valid with `done_i` |
| xfer_err_i | input | 1 | Transport failure, valid with `done_i` |
| switch_reset_o | output | 1 | Reset pulse to the switch |
| done_o | output | 1 | Sequence completed successfully |
| err_o | output | 1 | Sequence aborted |
| err_code_o | output | 2 | 0 none, 1 unknown device, 2 verify mismatch, 3 transport |
| chip_id_o | output | 16 | Identity field read from the switch |
| chip_rev_o | output | 4 | Revision field read from the switch |

## Verification
The bench builds the block with a 3-cycle reset pulse and a 5-cycle post-reset wait. This keeps the exact pulse width and the quiet window short enough to measure on every run, and a full sequence takes only a few dozen cycles. With runs that short, the bench sweeps every mailbox class, accepted and rejected identity words, two transport latencies, a transport error injected at each of the eight transfer positions, and readback corruptions both inside and outside each verify mask.

// File: rtl/sw_bringup_pkg.sv
package sw_bringup_pkg;

  localparam int unsigned NUM_STEPS = 8;
  localparam int unsigned STEP_W    = $clog2(NUM_STEPS);
  localparam int unsigned BLK_W     = 3;
  localparam int unsigned SUB_W     = 4;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ID_W      = 16;
  localparam int unsigned REV_W     = 4;
  localparam int unsigned ID_LSB    = 12;
  localparam int unsigned REV_LSB   = 28;

  localparam logic [ID_W-1:0] ID_ACCEPT_A = 16'h7385;
  localparam logic [ID_W-1:0] ID_ACCEPT_B = 16'h7395;

  localparam logic [BLK_W-1:0]  BLK_SYS   = 3'd7;
  localparam logic [BLK_W-1:0]  BLK_PORT  = 3'd1;
  localparam logic [SUB_W-1:0]  SUB_HOST  = 4'd6;
  localparam logic [ADDR_W-1:0] A_MBOX    = 8'h15;
  localparam logic [ADDR_W-1:0] A_IDENT   = 8'h18;
  localparam logic [ADDR_W-1:0] A_CLKDLY  = 8'h05;
  localparam logic [ADDR_W-1:0] A_PMODE   = 8'h19;
  localparam logic [ADDR_W-1:0] A_MACCFG  = 8'h00;

  localparam logic [DATA_W-1:0] V_CLKDLY  = 32'h0000_0033;
  localparam logic [DATA_W-1:0] M_CLKDLY  = 32'h0000_0033;
  localparam logic [DATA_W-1:0] V_PMODE   = (32'd1 << 5) | (32'd1 << 3) | (32'd1 << 2);
  localparam logic [DATA_W-1:0] M_PMODE   = 32'h0000_00FF;
  localparam logic [DATA_W-1:0] V_MAC_RST = (32'd1 << 29) | (32'd1 << 5) | (32'd1 << 4);
  localparam logic [DATA_W-1:0] V_MAC_RUN = (32'd1 << 28) | (32'd1 << 18) | (32'd1 << 17) |
                                            (32'd1 << 16) | (32'd6 << 6) | 32'd4;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_NODEV = 2'd1,
    ERR_IO    = 2'd2,
    ERR_XPORT = 2'd3
  } err_code_e;

  typedef struct packed {
    logic              wr;
    logic [BLK_W-1:0]  blk;
    logic [SUB_W-1:0]  sub;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;   // write value, or expected value on verify reads
    logic [DATA_W-1:0] mask;
    logic              verify;
  } step_t;

endpackage

// File: rtl/sw_step_table.sv
module sw_step_table
  import sw_bringup_pkg::*;
(
  input  logic [STEP_W-1:0] idx_i,
  output step_t             step_o
);

  function automatic step_t mk(logic wr, logic [BLK_W-1:0] blk, logic [SUB_W-1:0] sub,
                               logic [ADDR_W-1:0] addr, logic [DATA_W-1:0] data,
                               logic [DATA_W-1:0] mask, logic verify);
    step_t s;
    s.wr = wr; s.blk = blk; s.sub = sub; s.addr = addr;
    s.data = data; s.mask = mask; s.verify = verify;
    return s;
  endfunction

  always_comb begin
    unique case (idx_i)
      3'd0:    step_o = mk(1'b0, BLK_SYS,  4'd0,     A_MBOX,   '0,        '0,       1'b0);
      3'd1:    step_o = mk(1'b0, BLK_SYS,  4'd0,     A_IDENT,  '0,        '0,       1'b0);
      3'd2:    step_o = mk(1'b1, BLK_SYS,  4'd0,     A_CLKDLY, V_CLKDLY,  '0,       1'b0);
      3'd3:    step_o = mk(1'b0, BLK_SYS,  4'd0,     A_CLKDLY, V_CLKDLY,  M_CLKDLY, 1'b1);
      3'd4:    step_o = mk(1'b1, BLK_PORT, SUB_HOST, A_PMODE,  V_PMODE,   '0,       1'b0);
      3'd5:    step_o = mk(1'b0, BLK_PORT, SUB_HOST, A_PMODE,  V_PMODE,   M_PMODE,  1'b1);
      3'd6:    step_o = mk(1'b1, BLK_PORT, SUB_HOST, A_MACCFG, V_MAC_RST, '0,       1'b0);
      default: step_o = mk(1'b1, BLK_PORT, SUB_HOST, A_MACCFG, V_MAC_RUN, '0,       1'b0);
    endcase
  end

endmodule

// File: rtl/sw_xact_port.sv
module sw_xact_port
  import sw_bringup_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              wr_i,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic [SUB_W-1:0]  sub_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              xerr_i,
  output logic              req_o,
  output logic              wr_o,
  output logic [BLK_W-1:0]  blk_o,
  output logic [SUB_W-1:0]  sub_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              fin_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              xerr_o
);

  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      wr_o    <= 1'b0;
      blk_o   <= '0;
      sub_o   <= '0;
      addr_o  <= '0;
      wdata_o <= '0;
      fin_o   <= 1'b0;
      rdata_o <= '0;
      xerr_o  <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (!busy_q && launch_i) begin
        busy_q  <= 1'b1;
        wr_o    <= wr_i;
        blk_o   <= blk_i;
        sub_o   <= sub_i;
        addr_o  <= addr_i;
        wdata_o <= wr_i ? wdata_i : '0;
      end else if (busy_q && done_i) begin
        busy_q  <= 1'b0;
        fin_o   <= 1'b1;
        rdata_o <= rdata_i;
        xerr_o  <= xerr_i;
      end
    end
  end

  assign req_o = busy_q;

endmodule

// File: rtl/sw_reset_timer.sv
module sw_reset_timer #(
  parameter int unsigned PULSE_CYCLES = 1000,
  parameter int unsigned WAIT_CYCLES  = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic rst_o,
  output logic fin_o
);

  localparam int unsigned MAX_CYC = (PULSE_CYCLES > WAIT_CYCLES) ? PULSE_CYCLES : WAIT_CYCLES;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [1:0] {T_IDLE, T_PULSE, T_HOLD} phase_e;

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= T_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        T_IDLE: if (start_i) begin
          phase_q <= T_PULSE;
          cnt_q   <= CNT_W'(PULSE_CYCLES - 1);
        end
        T_PULSE: if (cnt_q == '0) begin
          phase_q <= T_HOLD;
          cnt_q   <= CNT_W'(WAIT_CYCLES - 1);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        default: if (cnt_q == '0) phase_q <= T_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
      endcase
    end
  end

  assign rst_o = (phase_q == T_PULSE);
  assign fin_o = (phase_q == T_HOLD) && (cnt_q == '0);

endmodule

// File: rtl/sw_bringup_seq.sv
module sw_bringup_seq
  import sw_bringup_pkg::*;
#(
  parameter int unsigned RST_PULSE_CYCLES = 1000,
  parameter int unsigned RST_WAIT_CYCLES  = 10000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic        req_o,
  output logic        req_write_o,
  output logic [2:0]  req_block_o,
  output logic [3:0]  req_subblock_o,
  output logic [7:0]  req_reg_o,
  output logic [31:0] req_wdata_o,
  input  logic        done_i,
  input  logic [31:0] rdata_i,
  input  logic        xfer_err_i,
  output logic        switch_reset_o,
  output logic        done_o,
  output logic        err_o,
  output logic [1:0]  err_code_o,
  output logic [15:0] chip_id_o,
  output logic [3:0]  chip_rev_o
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  typedef enum logic [2:0] {S_LAUNCH, S_WAIT, S_RESET, S_DONE, S_FAIL} state_e;

  state_e            state_q;
  logic [STEP_W-1:0] step_q;
  err_code_e         code_q;
  logic [ID_W-1:0]   id_q;
  logic [REV_W-1:0]  rev_q;

  step_t             cur;
  logic              x_fin, x_err;
  logic [DATA_W-1:0] x_rdata;
  logic              tmr_start, tmr_fin;
  logic [ID_W-1:0]   rd_id;
  logic              id_ok, mbox_dead, vfy_bad;

  sw_step_table u_table (
    .idx_i  (step_q),
    .step_o (cur)
  );

  sw_xact_port u_xact (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(state_q == S_LAUNCH),
    .wr_i    (cur.wr),
    .blk_i   (cur.blk),
    .sub_i   (cur.sub),
    .addr_i  (cur.addr),
    .wdata_i (cur.data),
    .done_i  (done_i),
    .rdata_i (rdata_i),
    .xerr_i  (xfer_err_i),
    .req_o   (req_o),
    .wr_o    (req_write_o),
    .blk_o   (req_block_o),
    .sub_o   (req_subblock_o),
    .addr_o  (req_reg_o),
    .wdata_o (req_wdata_o),
    .fin_o   (x_fin),
    .rdata_o (x_rdata),
    .xerr_o  (x_err)
  );

  sw_reset_timer #(
    .PULSE_CYCLES(RST_PULSE_CYCLES),
    .WAIT_CYCLES (RST_WAIT_CYCLES)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(tmr_start),
    .rst_o  (switch_reset_o),
    .fin_o  (tmr_fin)
  );

  assign rd_id     = x_rdata[ID_LSB +: ID_W];
  assign id_ok     = (rd_id == ID_ACCEPT_A) || (rd_id == ID_ACCEPT_B);
  assign mbox_dead = &x_rdata;
  assign vfy_bad   = cur.verify && ((x_rdata & cur.mask) != cur.data);
  assign tmr_start = (state_q == S_WAIT) && x_fin && !x_err &&
                     (step_q == '0) && mbox_dead;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_LAUNCH;
      step_q  <= '0;
      code_q  <= ERR_NONE;
      id_q    <= '0;
      rev_q   <= '0;
    end else begin
      unique case (state_q)
        S_LAUNCH: state_q <= S_WAIT;
        S_WAIT: if (x_fin) begin
          if (x_err) begin
            state_q <= S_FAIL;
            code_q  <= ERR_XPORT;
          end else if (step_q == '0) begin
            state_q <= mbox_dead ? S_RESET : S_LAUNCH;
            step_q  <= mbox_dead ? step_q : step_q + 1'b1;
          end else if (step_q == STEP_W'(1)) begin
            id_q  <= rd_id;
            rev_q <= x_rdata[REV_LSB +: REV_W];
            if (id_ok) begin
              state_q <= S_LAUNCH;
              step_q  <= step_q + 1'b1;
            end else begin
              state_q <= S_FAIL;
              code_q  <= ERR_NODEV;
            end
          end else if (vfy_bad) begin
            state_q <= S_FAIL;
            code_q  <= ERR_IO;
          end else if (step_q == LAST_STEP) begin
            state_q <= S_DONE;
          end else begin
            state_q <= S_LAUNCH;
            step_q  <= step_q + 1'b1;
          end
        end
        S_RESET: if (tmr_fin) begin
          state_q <= S_LAUNCH;
          step_q  <= STEP_W'(1);
        end
        default: state_q <= state_q;
      endcase
    end
  end

  assign done_o     = (state_q == S_DONE);
  assign err_o      = (state_q == S_FAIL);
  assign err_code_o = code_q;
  assign chip_id_o  = id_q;
  assign chip_rev_o = rev_q;

endmodule

// File: rtl/sw_bringup_seq_chk.sv
module sw_bringup_seq_chk #(
  parameter int unsigned RST_PULSE_CYCLES = 1000
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_o,
  input logic        req_write_o,
  input logic [2:0]  req_block_o,
  input logic [3:0]  req_subblock_o,
  input logic [7:0]  req_reg_o,
  input logic [31:0] req_wdata_o,
  input logic        done_i,
  input logic        switch_reset_o,
  input logic        done_o,
  input logic        err_o,
  input logic [1:0]  err_code_o
);

  logic [31:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_cnt_q <= '0;
    else         hi_cnt_q <= switch_reset_o ? hi_cnt_q + 1 : '0;
  end

  assert_req_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !done_i |=> req_o);

  assert_fields_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !done_i |=> $stable(req_write_o) && $stable(req_block_o) &&
      $stable(req_subblock_o) && $stable(req_reg_o) && $stable(req_wdata_o));

  assert_req_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && done_i |=> !req_o);

  assert_no_req_in_reset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_reset_o |-> !req_o);

  assert_pulse_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_reset_o |-> hi_cnt_q < RST_PULSE_CYCLES);

  assert_done_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && !req_o);

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o && $stable(err_code_o) && !req_o);

  assert_outcome_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  assert_err_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> err_code_o != 2'd0);

endmodule

bind sw_bringup_seq sw_bringup_seq_chk #(.RST_PULSE_CYCLES(RST_PULSE_CYCLES)) u_chk (.*);

// File: tb/sw_bringup_seq_bench.sv
module sw_bringup_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE = 3;
  localparam int WAITC = 5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_o, req_write_o;
  logic [2:0]  req_block_o;
  logic [3:0]  req_subblock_o;
  logic [7:0]  req_reg_o;
  logic [31:0] req_wdata_o;
  logic        done_i = 1'b0;
  logic [31:0] rdata_i = '0;
  logic        xfer_err_i = 1'b0;
  logic        switch_reset_o, done_o, err_o;
  logic [1:0]  err_code_o;
  logic [15:0] chip_id_o;
  logic [3:0]  chip_rev_o;

  sw_bringup_seq #(.RST_PULSE_CYCLES(PULSE), .RST_WAIT_CYCLES(WAITC)) u_sw_bringup_seq (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0, failures = 0;
  // transport model
  logic [31:0] mb_val, chip_word, flip_clk, flip_adv, m_clk, m_adv, m_mac;
  int lat = 0, err_at = -1, n_txn = 0, wcnt = 0;
  bit stray = 0;
  logic        l_wr[32];
  logic [2:0]  l_blk[32];
  logic [3:0]  l_sub[32];
  logic [7:0]  l_addr[32];
  logic [31:0] l_wd[32];
  // expected sequence
  logic        e_wr[16];
  logic [2:0]  e_blk[16];
  logic [3:0]  e_sub[16];
  logic [7:0]  e_addr[16];
  logic [31:0] e_wd[16];
  int e_n;
  // monitors
  int cyc = 0, pulses = 0, hi_len = 0, last_hi = 0, fall_cyc = -1, gap = -1, stab_err = 0;
  bit prev_rst = 0, prev_req = 0, gap_pend = 0;
  logic [51:0] snap;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk_i);
      if (!rst_ni) begin
        done_i = 0; xfer_err_i = 0; wcnt = 0;
      end else if (done_i) begin
        done_i = 0; xfer_err_i = 0;
      end else if (req_o) begin
        if (wcnt < lat) wcnt++;
        else begin
          wcnt = 0;
          if (n_txn < 32) begin
            l_wr[n_txn] = req_write_o; l_blk[n_txn] = req_block_o; l_sub[n_txn] = req_subblock_o;
            l_addr[n_txn] = req_reg_o; l_wd[n_txn] = req_wdata_o;
          end
          xfer_err_i = (n_txn == err_at);
          rdata_i = 32'hDEAD_BEEF;
          if (req_write_o) begin
            if (req_block_o == 7 && req_reg_o == 8'h05) m_clk = req_wdata_o ^ flip_clk;
            if (req_block_o == 1 && req_reg_o == 8'h19) m_adv = req_wdata_o ^ flip_adv;
            if (req_block_o == 1 && req_reg_o == 8'h00) m_mac = req_wdata_o;
          end else begin
            if (req_block_o == 7 && req_reg_o == 8'h15) rdata_i = mb_val;
            if (req_block_o == 7 && req_reg_o == 8'h18) rdata_i = chip_word;
            if (req_block_o == 7 && req_reg_o == 8'h05) rdata_i = m_clk;
            if (req_block_o == 1 && req_reg_o == 8'h19) rdata_i = m_adv;
          end
          n_txn++;
          done_i = 1;
        end
      end else if (stray) begin
        done_i = 1; xfer_err_i = 1; rdata_i = '1; stray = 0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk_i);
      cyc++;
      if (switch_reset_o) begin
        if (!prev_rst) begin pulses++; hi_len = 0; end
        hi_len++;
      end else if (prev_rst) begin
        last_hi = hi_len; fall_cyc = cyc; gap_pend = 1;
      end
      if (req_o && !prev_req) begin
        snap = {req_write_o, req_block_o, req_subblock_o, req_reg_o, req_wdata_o};
        if (gap_pend) begin gap = cyc - fall_cyc; gap_pend = 0; end
      end else if (req_o && snap != {req_write_o, req_block_o, req_subblock_o, req_reg_o, req_wdata_o})
        stab_err++;
      prev_rst = switch_reset_o;
      prev_req = req_o;
    end
  end

  task automatic push(logic wr, logic [2:0] b, logic [3:0] s, logic [7:0] a, logic [31:0] d);
    e_wr[e_n] = wr; e_blk[e_n] = b; e_sub[e_n] = s; e_addr[e_n] = a; e_wd[e_n] = d;
    e_n++;
  endtask

  task automatic run(logic [31:0] mb, logic [31:0] cw, int l, int ea,
                     logic [31:0] fc, logic [31:0] fa, string tag);
    int code;
    bit stop, exp_rst, id_read, seq_ok;
    logic [15:0] id;
    int n_end;
    mb_val = mb; chip_word = cw; lat = l; err_at = ea; flip_clk = fc; flip_adv = fa;
    m_clk = '0; m_adv = '0; m_mac = '0;
    rst_ni = 0;
    repeat (3) @(negedge clk_i);
    chk(!req_o && !switch_reset_o && !done_o && !err_o && err_code_o == 0,
        {"R1 reset state ", tag}, {req_o, switch_reset_o, done_o, err_o, err_code_o}, 0);
    n_txn = 0; pulses = 0; gap = -1; gap_pend = 0; stab_err = 0; last_hi = 0;
    rst_ni = 1;
    // expected outcome from the requirements
    e_n = 0; code = 0; stop = 0; exp_rst = 0; id_read = 0;
    id = cw[27:12];
    push(0, 7, 0, 8'h15, 0);
    if (ea == 0) begin code = 3; stop = 1; end
    else exp_rst = (mb == 32'hFFFF_FFFF);
    if (!stop) begin
      push(0, 7, 0, 8'h18, 0);
      if (ea == 1) begin code = 3; stop = 1; end
      else begin
        id_read = 1;
        if (id != 16'h7385 && id != 16'h7395) begin code = 1; stop = 1; end
      end
    end
    if (!stop) begin push(1, 7, 0, 8'h05, 32'h33); if (ea == 2) begin code = 3; stop = 1; end end
    if (!stop) begin
      push(0, 7, 0, 8'h05, 0);
      if (ea == 3) begin code = 3; stop = 1; end
      else if (((32'h33 ^ fc) & 32'h33) != 32'h33) begin code = 2; stop = 1; end
    end
    if (!stop) begin push(1, 1, 6, 8'h19, 32'h2C); if (ea == 4) begin code = 3; stop = 1; end end
    if (!stop) begin
      push(0, 1, 6, 8'h19, 0);
      if (ea == 5) begin code = 3; stop = 1; end
      else if (((32'h2C ^ fa) & 32'hFF) != 32'h2C) begin code = 2; stop = 1; end
    end
    if (!stop) begin push(1, 1, 6, 8'h00, 32'h2000_0030); if (ea == 6) begin code = 3; stop = 1; end end
    if (!stop) begin push(1, 1, 6, 8'h00, 32'h1007_0184); if (ea == 7) begin code = 3; stop = 1; end end
    begin : wait_end
      for (int i = 0; i < 2000; i++) begin
        @(negedge clk_i);
        if (done_o || err_o) disable wait_end;
      end
      chk(0, {"R9 run timeout ", tag}, 0, 1);
    end
    // sequence content
    seq_ok = (n_txn == e_n);
    for (int i = 0; i < e_n && i < n_txn; i++)
      if (l_wr[i] != e_wr[i] || l_blk[i] != e_blk[i] || l_sub[i] != e_sub[i] ||
          l_addr[i] != e_addr[i] || (e_wr[i] && l_wd[i] != e_wd[i])) seq_ok = 0;
    chk(seq_ok, {"R1 R3 R4 R5 R6 R7 request sequence ", tag}, n_txn, e_n);
    chk(err_code_o == code[1:0] && done_o == (code == 0) && err_o == (code != 0),
        {"R3 R4 R5 R6 R7 outcome ", tag}, {done_o, err_o, err_code_o}, {(code == 0), (code != 0), code[1:0]});
    chk(pulses == (exp_rst ? 1 : 0), {"R2 pulse count ", tag}, pulses, exp_rst);
    if (exp_rst) begin
      chk(last_hi == PULSE, {"R2 pulse width ", tag}, last_hi, PULSE);
      if (e_n > 1) chk(gap >= WAITC, {"R2 post-reset quiet ", tag}, gap, WAITC);
    end
    if (id_read) chk(chip_id_o == id && chip_rev_o == cw[31:28], {"R3 id fields ", tag},
                     {chip_rev_o, chip_id_o}, {cw[31:28], id});
    if (code == 0) chk(m_mac == 32'h1007_0184, {"R6 final mac value ", tag}, m_mac, 32'h1007_0184);
    chk(stab_err == 0, {"R8 fields stable ", tag}, stab_err, 0);
    // stray done after the end, then quiet period
    n_end = n_txn;
    @(negedge clk_i); stray = 1;
    repeat (20) @(negedge clk_i);
    chk(n_txn == n_end && done_o == (code == 0) && err_o == (code != 0) && err_code_o == code[1:0],
        {"R8 R9 quiet and sticky ", tag}, {n_txn[7:0], done_o, err_o, err_code_o},
        {n_end[7:0], (code == 0), (code != 0), code[1:0]});
  endtask

  initial begin
    logic [31:0] mbs [3] = '{32'h0, 32'hFFFF_FFFF, 32'h1234_5678};
    logic [15:0] ids [4] = '{16'h7385, 16'h7395, 16'h7386, 16'h0000};
    for (int m = 0; m < 3; m++)
      for (int k = 0; k < 4; k++)
        for (int l = 0; l < 3; l += 2)
          run(mbs[m], {4'(m + k + 1), ids[k], 12'hA5C}, l, -1, 0, 0, "sweep");
    for (int e = 0; e < 8; e++) run(32'hFFFF_FFFF, {4'd2, 16'h7385, 12'h0}, e % 2, e, 0, 0, "R7 xport");
    run(32'h0, {4'd1, 16'h7395, 12'h0}, 1, -1, 32'h01, 0, "R4 clk mismatch");
    run(32'h0, {4'd1, 16'h7395, 12'h0}, 1, -1, 32'h40, 0, "R4 clk outside mask");
    run(32'h0, {4'd1, 16'h7395, 12'h0}, 0, -1, 0, 32'h80, "R5 mode mismatch");
    run(32'h0, {4'd1, 16'h7395, 12'h0}, 0, -1, 0, 32'h100, "R5 mode outside mask");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    checks++; failures++;
    $display("FAIL watchdog R9 actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule